// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Angle Register

This block is the digital front end of two angle channels that share one 16-bit data bus. Each channel catches the bus in a first-stage register that loads as two independent bytes. A second-stage 16-bit holding register then moves the whole first-stage word to the channel's converter at once. The holding register output is the channel's angle in natural binary. The most significant bit is worth 180 degrees, so the bus word 16'h8000 is half a turn.

Every enable is a level control sampled on the rising clock edge. While an enable is high its register follows its source. While it is low the register keeps its value. The surrounding chip ties unused enables high, which turns the block into a one-clock pass-through from bus to angle. The bus and all the enables are plain level inputs with no handshake. The block never stalls the bus, and a word that no enable captures is simply lost.

The block also checks the interface timing, counted in clock cycles from nanosecond parameters and the clock period. Three sticky flags per channel record violations of setup time, hold time and enable pulse width.

Top module: `dual_angle_latch`

## Requirements
- R1: While reset is low and after it is released, every angle output and every violation flag is zero. The angle outputs stay zero until an enable captures a new word.
- R2: At a clock edge where a channel's `hi_en` is high, that channel's upper first-stage byte takes `bus_word[15:8]`. `bus_word[15]` is the most significant angle bit.
- R3: At a clock edge where a channel's `lo_en` is high, that channel's lower first-stage byte takes `bus_word[7:0]`.
- R4: A first-stage byte whose enable is low keeps its value, whatever the bus carries.
- R5: At an edge where `xfer_en` is high, the holding register takes the first-stage word, including any byte loaded at that same edge. While `xfer_en` is low, the angle output does not change.
- R6: With all three enables of a channel high, its angle output equals the bus word sampled at the previous clock edge.
- R7: The enables of one channel change neither the angle nor the flags of the other channel.
- R8: A byte enable falls when it is sampled low after being sampled high. At that point the bus word must already have been present at the SETUP_CYC edges before the last high edge, where SETUP_CYC is 25 cycles by default. Otherwise `setup_viol` of that channel is set.
- R9: A bus change sampled at the edge where a byte enable is first seen low, or at any of the next HOLD_CYC-1 edges, sets `hold_viol` of that channel. HOLD_CYC is 7 by default.
- R10: Any of the three enables that falls after fewer than WIDTH_CYC consecutive high samples sets `width_viol` of that channel. WIDTH_CYC is 13 by default.
- R11: Once set, a violation flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word | input | 16 | Shared angle data bus, bit 15 is the MSB (180 degrees) |
| hi_en | input | 2 | Per-channel upper-byte load enable, level sensitive |
| lo_en | input | 2 | Per-channel lower-byte load enable, level sensitive |
| xfer_en | input | 2 | Per-channel transfer enable into the holding register |
| angle_out | output | 32 | Holding registers, channel c in bits [16c+15:16c] |
| setup_viol | output | 2 | Sticky setup-violation flag per channel |
| hold_viol | output | 2 | Sticky hold-violation flag per channel |
| width_viol | output | 2 | Sticky pulse-width violation flag per channel |

## Verification
A word stream with all enables high checks the pass-through latency and the bit order, using the MSB alone, the LSB alone, a mixed word and all ones. Separate byte loads, each followed by a different bus word, show which byte each enable owns and that an idle byte holds its value. A transfer with the byte enables low shows that the holding register reads the first stage and not the bus. Loading all three enables at the same edge checks the same-cycle path. Each timing limit is tested on both sides of its boundary (26 versus 25 stable edges, a change at 7 versus 6 edges, a width of 13 versus 12 samples), while the other channel shows it is unaffected.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef enum int {EN_HI = 0, EN_LO = 1, EN_XFER = 2} en_kind_e;
  localparam int NUM_EN = 3;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/dra_bus_watch.sv
module dra_bus_watch #(
  parameter int W     = 16,
  parameter int SAT   = 25,
  parameter int RUN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     bus,
  output logic             changed,
  output logic [RUN_W-1:0] stable_run
);
  logic [W-1:0] bus_q;

  assign changed = (bus != bus_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q      <= '0;
      stable_run <= '0;
    end else begin
      bus_q <= bus;
      if (changed)
        stable_run <= '0;
      else if (stable_run != RUN_W'(SAT))
        stable_run <= stable_run + 1'b1;
    end
  end

  p_run_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> stable_run == '0);
endmodule

// File: rtl/dra_enable_timer.sv
module dra_enable_timer #(
  parameter int SETUP_CYC  = 25,
  parameter int HOLD_CYC   = 7,
  parameter int WIDTH_CYC  = 13,
  parameter int RUN_W      = 5,
  parameter bit CHECK_DATA = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bus_changed,
  input  logic [RUN_W-1:0] stable_run,
  output logic             setup_flag,
  output logic             hold_flag,
  output logic             width_flag
);
  localparam int WC_W = $clog2(WIDTH_CYC + 1);
  localparam int HL_W = $clog2(HOLD_CYC + 1);

  logic            en_q;
  logic [WC_W-1:0] hi_cnt;
  logic [HL_W-1:0] hold_left;
  logic            fall, in_hold;
  logic            setup_hit, hold_hit, width_hit;

  assign fall      = en_q & ~en;
  assign in_hold   = fall | (hold_left != '0);
  assign setup_hit = CHECK_DATA && fall && (stable_run < RUN_W'(SETUP_CYC));
  assign hold_hit  = CHECK_DATA && in_hold && bus_changed;
  assign width_hit = fall && (hi_cnt < WC_W'(WIDTH_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      hi_cnt     <= '0;
      hold_left  <= '0;
      setup_flag <= 1'b0;
      hold_flag  <= 1'b0;
      width_flag <= 1'b0;
    end else begin
      en_q <= en;
      if (!en)
        hi_cnt <= '0;
      else if (hi_cnt != WC_W'(WIDTH_CYC))
        hi_cnt <= hi_cnt + 1'b1;
      if (fall)
        hold_left <= HL_W'(HOLD_CYC - 1);
      else if (hold_left != '0)
        hold_left <= hold_left - 1'b1;
      setup_flag <= setup_flag | setup_hit;
      hold_flag  <= hold_flag  | hold_hit;
      width_flag <= width_flag | width_hit;
    end
  end

  p_sticky_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    setup_flag |=> setup_flag);
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_flag |=> hold_flag);
  p_sticky_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    width_flag |=> width_flag);
  p_short_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDTH_CYC > 1 && en_q && !en && hi_cnt == WC_W'(1)) |=> width_flag);
  p_hold_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (CHECK_DATA && hold_left != '0 && bus_changed) |=> hold_flag);
endmodule

// File: rtl/dra_channel.sv
module dra_channel
  import dra_pkg::*;
#(
  parameter int W         = 16,
  parameter int SETUP_CYC = 25,
  parameter int HOLD_CYC  = 7,
  parameter int WIDTH_CYC = 13,
  parameter int RUN_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     bus,
  input  logic             bus_changed,
  input  logic [RUN_W-1:0] stable_run,
  input  logic             hi_en,
  input  logic             lo_en,
  input  logic             xfer_en,
  output logic [W-1:0]     angle,
  output logic             setup_viol,
  output logic             hold_viol,
  output logic             width_viol
);
  localparam int HALF = W / 2;

  logic [HALF-1:0]   s1_hi, s1_lo;
  logic [HALF-1:0]   s1_hi_nx, s1_lo_nx;
  logic [W-1:0]      hold_q;
  logic [NUM_EN-1:0] en_vec, su_f, ho_f, wi_f;

  // byte stage: next value doubles as the transfer source, giving same-edge pass-through
  assign s1_hi_nx = hi_en ? bus[W-1:HALF] : s1_hi;
  assign s1_lo_nx = lo_en ? bus[HALF-1:0] : s1_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_hi  <= '0;
      s1_lo  <= '0;
      hold_q <= '0;
    end else begin
      s1_hi <= s1_hi_nx;
      s1_lo <= s1_lo_nx;
      if (xfer_en)
        hold_q <= {s1_hi_nx, s1_lo_nx};
    end
  end

  assign angle = hold_q;

  always_comb begin
    en_vec          = '0;
    en_vec[EN_HI]   = hi_en;
    en_vec[EN_LO]   = lo_en;
    en_vec[EN_XFER] = xfer_en;
  end

  for (genvar k = 0; k < NUM_EN; k++) begin : g_tmr
    dra_enable_timer #(
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .WIDTH_CYC (WIDTH_CYC),
      .RUN_W     (RUN_W),
      .CHECK_DATA(k != int'(EN_XFER))
    ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_vec[k]),
      .bus_changed(bus_changed),
      .stable_run (stable_run),
      .setup_flag (su_f[k]),
      .hold_flag  (ho_f[k]),
      .width_flag (wi_f[k])
    );
  end

  assign setup_viol = |su_f;
  assign hold_viol  = |ho_f;
  assign width_viol = |wi_f;

  p_hi_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> s1_hi == $past(s1_hi));
  p_lo_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_en |=> s1_lo == $past(s1_lo));
  p_hi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |=> s1_hi == $past(bus[W-1:HALF]));
  p_lo_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_en |=> s1_lo == $past(bus[HALF-1:0]));
  p_xfer_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> angle == $past(angle));
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en && lo_en && xfer_en) |=> angle == $past(bus));
endmodule

// File: rtl/dual_angle_latch.sv
module dual_angle_latch
  import dra_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int W         = 16,
  parameter int CLK_NS    = 8,
  parameter int SETUP_NS  = 200,
  parameter int HOLD_NS   = 50,
  parameter int WIDTH_NS  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     bus_word,
  input  logic [NCH-1:0]   hi_en,
  input  logic [NCH-1:0]   lo_en,
  input  logic [NCH-1:0]   xfer_en,
  output logic [NCH*W-1:0] angle_out,
  output logic [NCH-1:0]   setup_viol,
  output logic [NCH-1:0]   hold_viol,
  output logic [NCH-1:0]   width_viol
);
  localparam int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
  localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_NS) < 1 ? 1 : ns_to_cyc(HOLD_NS, CLK_NS);
  localparam int WIDTH_CYC = ns_to_cyc(WIDTH_NS, CLK_NS) < 1 ? 1 : ns_to_cyc(WIDTH_NS, CLK_NS);
  localparam int RUN_W     = $clog2(SETUP_CYC + 1) < 1 ? 1 : $clog2(SETUP_CYC + 1);

  logic             bus_changed;
  logic [RUN_W-1:0] stable_run;

  dra_bus_watch #(.W(W), .SAT(SETUP_CYC), .RUN_W(RUN_W)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus       (bus_word),
    .changed   (bus_changed),
    .stable_run(stable_run)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dra_channel #(
      .W        (W),
      .SETUP_CYC(SETUP_CYC),
      .HOLD_CYC (HOLD_CYC),
      .WIDTH_CYC(WIDTH_CYC),
      .RUN_W    (RUN_W)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus        (bus_word),
      .bus_changed(bus_changed),
      .stable_run (stable_run),
      .hi_en      (hi_en[c]),
      .lo_en      (lo_en[c]),
      .xfer_en    (xfer_en[c]),
      .angle      (angle_out[c*W +: W]),
      .setup_viol (setup_viol[c]),
      .hold_viol  (hold_viol[c]),
      .width_viol (width_viol[c])
    );
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (angle_out == '0 && setup_viol == '0 && hold_viol == '0 && width_viol == '0));
endmodule

// File: tb/dual_angle_latch_tb.sv
module dual_angle_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_word = '0;
  logic [1:0]  hi_en = 2'b11, lo_en = 2'b11, xfer_en = 2'b11;
  logic [31:0] angle_out;
  logic [1:0]  setup_viol, hold_viol, width_viol;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_angle_latch u_dut (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word),
    .hi_en(hi_en), .lo_en(lo_en), .xfer_en(xfer_en),
    .angle_out(angle_out), .setup_viol(setup_viol),
    .hold_viol(hold_viol), .width_viol(width_viol)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flags_clear(input string req);
    chk(setup_viol == 0 && hold_viol == 0 && width_viol == 0, req, "no flags",
        {26'd0, setup_viol, hold_viol, width_viol}, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_word = '0; hi_en = 2'b11; lo_en = 2'b11; xfer_en = 2'b11;
    tick(3);
    rst_n = 1'b1;
    tick(40);
  endtask

  // kind 0 = upper byte, 1 = lower byte, 2 = transfer; timing kept legal
  task automatic pulse(input int ch, input int kind, input logic [15:0] w);
    @(negedge clk);
    bus_word = w;
    if (kind == 0) hi_en[ch] = 1'b1;
    else if (kind == 1) lo_en[ch] = 1'b1;
    else xfer_en[ch] = 1'b1;
    tick(30);
    hi_en[ch] = 1'b0; lo_en[ch] = 1'b0; xfer_en[ch] = 1'b0;
    tick(10);
  endtask

  task automatic t_reset();
    do_reset();
    chk(angle_out == 32'd0, "R1", "angles after reset", angle_out, 32'd0);
    flags_clear("R1");
  endtask

  task automatic t_passthrough();
    logic [15:0] words [4] = '{16'h8000, 16'h0001, 16'hA5C3, 16'hFFFF};
    foreach (words[i]) begin
      @(negedge clk);
      bus_word = words[i];
      @(negedge clk);
      chk(angle_out[15:0] == words[i], "R6", "ch0 pass-through", {16'd0, angle_out[15:0]}, {16'd0, words[i]});
      chk(angle_out[31:16] == words[i], "R6", "ch1 pass-through", {16'd0, angle_out[31:16]}, {16'd0, words[i]});
    end
    tick(30);
    hi_en = 2'b00; lo_en = 2'b00; xfer_en = 2'b00;
    tick(10);
    flags_clear("R8");
  endtask

  task automatic t_byte_load();
    pulse(0, 0, 16'h5A3C);
    pulse(0, 1, 16'h0FF0);
    chk(angle_out[15:0] == 16'hFFFF, "R5", "angle held while xfer low", {16'd0, angle_out[15:0]}, 32'hFFFF);
    pulse(0, 2, 16'hFFFF);
    chk(angle_out[15:0] == 16'h5AF0, "R2", "bytes assembled (R3 R4)", {16'd0, angle_out[15:0]}, 32'h5AF0);
    chk(angle_out[31:16] == 16'hFFFF, "R7", "ch1 untouched", {16'd0, angle_out[31:16]}, 32'hFFFF);
    flags_clear("R7");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    bus_word = 16'h1234;
    hi_en[1] = 1'b1; lo_en[1] = 1'b1; xfer_en[1] = 1'b1;
    @(negedge clk);
    chk(angle_out[31:16] == 16'h1234, "R5", "same-edge load", {16'd0, angle_out[31:16]}, 32'h1234);
    tick(29);
    hi_en[1] = 1'b0; lo_en[1] = 1'b0; xfer_en[1] = 1'b0;
    tick(10);
    chk(angle_out[15:0] == 16'h5AF0, "R7", "ch0 untouched", {16'd0, angle_out[15:0]}, 32'h5AF0);
    flags_clear("R5");
  endtask

  task automatic t_stale_xfer();
    pulse(0, 2, 16'h9999);
    chk(angle_out[15:0] == 16'h5AF0, "R5", "xfer takes first stage", {16'd0, angle_out[15:0]}, 32'h5AF0);
    chk(angle_out[31:16] == 16'h1234, "R4", "ch1 stage held", {16'd0, angle_out[31:16]}, 32'h1234);
  endtask

  task automatic t_setup();
    do_reset();
    @(negedge clk);
    bus_word = 16'h1111;
    tick(25);
    @(negedge clk);
    hi_en[0] = 1'b0;
    tick(12);
    chk(setup_viol[0] == 1'b0, "R8", "26 stable edges ok", {31'd0, setup_viol[0]}, 32'd0);
    @(negedge clk);
    bus_word = 16'h2222; hi_en[0] = 1'b1;
    tick(25);
    hi_en[0] = 1'b0;
    tick(12);
    chk(setup_viol[0] == 1'b1, "R8", "25 stable edges flagged", {31'd0, setup_viol[0]}, 32'd1);
    chk(setup_viol[1] == 1'b0 && hold_viol == 0 && width_viol == 0, "R7", "other flags clear",
        {26'd0, setup_viol, hold_viol, width_viol}, 32'h10);
    tick(20);
    chk(setup_viol[0] == 1'b1, "R11", "setup flag sticky", {31'd0, setup_viol[0]}, 32'd1);
  endtask

  task automatic t_hold();
    do_reset();
    @(negedge clk);
    lo_en[1] = 1'b0;
    tick(7);
    bus_word = 16'h3333;
    tick(5);
    chk(hold_viol[1] == 1'b0, "R9", "change at 7 edges ok", {31'd0, hold_viol[1]}, 32'd0);
    @(negedge clk);
    lo_en[1] = 1'b1;
    tick(30);
    lo_en[1] = 1'b0;
    tick(6);
    bus_word = 16'h4444;
    tick(3);
    chk(hold_viol[1] == 1'b1, "R9", "change at 6 edges flagged", {31'd0, hold_viol[1]}, 32'd1);
    chk(hold_viol[0] == 1'b0 && setup_viol == 0, "R7", "ch0 hold and setup clear",
        {28'd0, setup_viol, hold_viol}, 32'h2);
  endtask

  task automatic t_width();
    do_reset();
    @(negedge clk);
    xfer_en[0] = 1'b0;
    tick(20);
    xfer_en[0] = 1'b1;
    tick(13);
    xfer_en[0] = 1'b0;
    tick(3);
    chk(width_viol[0] == 1'b0, "R10", "13-sample pulse ok", {31'd0, width_viol[0]}, 32'd0);
    xfer_en[0] = 1'b1;
    tick(12);
    xfer_en[0] = 1'b0;
    tick(3);
    chk(width_viol[0] == 1'b1, "R10", "12-sample pulse flagged", {31'd0, width_viol[0]}, 32'd1);
    chk(width_viol[1] == 1'b0, "R7", "ch1 width clear", {31'd0, width_viol[1]}, 32'd0);
    do_reset();
    chk(width_viol == 0, "R11", "flag cleared only by reset", {30'd0, width_viol}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_byte_load();
    t_same_cycle();
    t_stale_xfer();
    t_setup();
    t_hold();
    t_width();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule